// File: doc/BRIEF.md
# Descriptor Ring Index Controller

This block keeps the index state of two circular descriptor queues that software and a DMA engine share, one for the receive direction and one for the transmit direction. Each ring has a size register, holding the number of descriptors minus one, and two indices that wrap to zero after they reach that value. On the receive ring the hardware moves the produce index forward as it stores frames, and software moves the consume index to give buffers back. On the transmit ring software moves the produce index to hand descriptors over, and the hardware moves the consume index as it sends them.

The DMA engine pulses an advance input when it finishes a descriptor. With that pulse it passes the descriptor's interrupt-request bit and an error flag. The block rejects an advance that the ring state does not permit and records an overrun or underrun instead. It merges ten interrupt sources into a status register, an enable register and a write-one-to-clear path, and drives a single interrupt line from them. Software writes the sizes and its own indices through a small write port.

Top module: `dring_ctrl`

## Requirements
- R1: After reset both size registers hold MAX_DESC-1 (15 by default). All four indices, `int_status` and `int_en` are zero, and `irq`, `rx_pending`, `rx_full`, `tx_pending` and `tx_full` are low.
- R2: A write with `sw_addr`=0 (receive size) or `sw_addr`=2 (transmit size) and a value no larger than MAX_DESC-1 loads that ring's size. The same write sets both indices of that ring to zero on the next clock edge.
- R3: A write with `sw_addr`=1 loads the receive consume index, and a write with `sw_addr`=3 loads the transmit produce index. Either write is ignored when the value is greater than the ring's size register, and the index keeps its old value.
- R4: An accepted hardware advance moves that ring's hardware index forward by one. When the index is equal to the size register, the advance sets it to 0.
- R5: `rx_pending` and `tx_pending` are high whenever produce differs from consume. `rx_full` and `tx_full` are high when produce+1, wrapped to the ring size, equals consume.
- R6: A receive advance while `rx_full` is high is refused: `rx_prod` stays the same and status bit 0 (rx overrun) is set. A transmit advance while the ring is empty is refused: `tx_cons` stays the same and status bit 4 (tx underrun) is set.
- R7: A transmit advance that makes consume equal to produce sets status bit 6 (tx finished). A receive advance that leaves the ring with no free descriptor sets status bit 2 (rx finished).
- R8: An accepted advance sets the done bit (bit 3 for receive, bit 7 for transmit) only when its interrupt-request input is high. It sets the error bit (bit 1 for receive, bit 5 for transmit) only when its error input is high.
- R9: `soft_int_set` sets status bit 8 and `wake_evt` sets status bit 9.
- R10: A write with `int_en_we` loads `int_en`. `irq` is high exactly while `int_status & int_en` is non-zero.
- R11: A write with `int_clr_we` clears every status bit whose `int_clr_wdata` bit is one. If a new event sets a bit in the same cycle that the bit is cleared, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software write strobe for size and index registers |
| sw_addr | input | 2 | 0 rx size, 1 rx consume, 2 tx size, 3 tx produce |
| sw_wdata | input | IDX_W | Software write value |
| int_en_we | input | 1 | Interrupt enable write strobe |
| int_en_wdata | input | 10 | New interrupt enable mask |
| int_clr_we | input | 1 | Interrupt clear write strobe |
| int_clr_wdata | input | 10 | Write-one-to-clear mask |
| soft_int_set | input | 1 | Raise the software interrupt bit |
| wake_evt | input | 1 | Raise the wakeup interrupt bit |
| rx_adv | input | 1 | Receive DMA finished storing a descriptor |
| rx_adv_irq | input | 1 | Interrupt-request bit of that receive descriptor |
| rx_adv_err | input | 1 | Receive descriptor finished with an error |
| tx_adv | input | 1 | Transmit DMA finished a descriptor |
| tx_adv_irq | input | 1 | Interrupt-request bit of that transmit descriptor |
| tx_adv_err | input | 1 | Transmit descriptor finished with an error |
| rx_cnt | output | IDX_W | Receive size register (descriptors minus one) |
| rx_prod | output | IDX_W | Receive produce index (hardware) |
| rx_cons | output | IDX_W | Receive consume index (software) |
| tx_cnt | output | IDX_W | Transmit size register (descriptors minus one) |
| tx_prod | output | IDX_W | Transmit produce index (software) |
| tx_cons | output | IDX_W | Transmit consume index (hardware) |
| rx_pending | output | 1 | Receive ring holds unread frames |
| rx_full | output | 1 | Receive ring has no free descriptor |
| tx_pending | output | 1 | Transmit ring holds unsent descriptors |
| tx_full | output | 1 | Transmit ring has no free descriptor |
| int_status | output | 10 | Interrupt status bits |
| int_en | output | 10 | Interrupt enable bits |
| irq | output | 1 | Interrupt request line |

## Verification
The assertions rely on the size registers being written only with values below MAX_DESC. They also rely on a transmit size of at least one whenever the empty and full flags are compared. Some properties require that no size write, clear write or competing set event lands in the same cycle as the event they watch. The directed stimulus changes inputs on the falling edge and applies at most one write or advance per cycle, so every property sees one isolated cause at a time. All programmed sizes are 3, so each boundary is reached within a few advances.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int IRQ_W     = 10;
  localparam int B_RX_OVR  = 0;
  localparam int B_RX_ERR  = 1;
  localparam int B_RX_FIN  = 2;
  localparam int B_RX_DONE = 3;
  localparam int B_TX_UND  = 4;
  localparam int B_TX_ERR  = 5;
  localparam int B_TX_FIN  = 6;
  localparam int B_TX_DONE = 7;
  localparam int B_SOFT    = 8;
  localparam int B_WAKE    = 9;

  typedef enum logic [1:0] {
    SEL_RX_CNT = 2'd0,
    SEL_RX_SW  = 2'd1,
    SEL_TX_CNT = 2'd2,
    SEL_TX_SW  = 2'd3
  } sw_sel_e;

  typedef struct packed {
    logic done;
    logic err;
    logic fin;
    logic refuse;
  } ring_ev_t;
endpackage

// File: rtl/dring_ring.sv
module dring_ring
  import dring_pkg::*;
#(
  parameter int MAX_DESC    = 16,
  parameter int IDX_W       = 4,
  parameter bit HW_PRODUCES = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_we,
  input  logic             sw_idx_we,
  input  logic [IDX_W-1:0] wdata,
  input  logic             hw_adv,
  input  logic             hw_irq,
  input  logic             hw_err,
  output logic [IDX_W-1:0] cnt,
  output logic [IDX_W-1:0] prod,
  output logic [IDX_W-1:0] cons,
  output logic             pending,
  output logic             full,
  output ring_ev_t         ev
);
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(MAX_DESC - 1);

  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] sw_q, sw_d;
  logic [IDX_W-1:0] hw_q, hw_d;
  logic [IDX_W-1:0] hw_next;
  logic             hw_ok;
  logic             fin_after;
  logic             empty;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i,
                                            input logic [IDX_W-1:0] lim);
    return (i == lim) ? '0 : i + IDX_W'(1);
  endfunction

  assign hw_next = step(hw_q, cnt_q);
  assign empty   = (prod == cons);
  assign full    = (step(prod, cnt_q) == cons);
  assign pending = !empty;

  generate
    if (HW_PRODUCES) begin : g_hw_prod
      assign prod      = hw_q;
      assign cons      = sw_q;
      assign hw_ok     = !full;
      assign fin_after = (step(hw_next, cnt_q) == sw_q);
    end else begin : g_hw_cons
      assign prod      = sw_q;
      assign cons      = hw_q;
      assign hw_ok     = !empty;
      assign fin_after = (hw_next == sw_q);
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    sw_d  = sw_q;
    hw_d  = hw_q;
    ev    = '0;
    if (cnt_we) begin
      if (wdata <= MAX_IDX) begin
        cnt_d = wdata;
        sw_d  = '0;
        hw_d  = '0;
      end
    end else begin
      if (sw_idx_we && (wdata <= cnt_q)) begin
        sw_d = wdata;
      end
      if (hw_adv) begin
        if (hw_ok) begin
          hw_d    = hw_next;
          ev.done = hw_irq;
          ev.err  = hw_err;
          ev.fin  = fin_after;
        end else begin
          ev.refuse = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= MAX_IDX;
      sw_q  <= '0;
      hw_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sw_q  <= sw_d;
      hw_q  <= hw_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dring_irq.sv
module dring_irq #(
  parameter int IRQ_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_vec,
  input  logic             en_we,
  input  logic [IRQ_W-1:0] en_wdata,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_wdata,
  output logic [IRQ_W-1:0] status,
  output logic [IRQ_W-1:0] en,
  output logic             irq
);
  logic [IRQ_W-1:0] stat_q, stat_d;
  logic [IRQ_W-1:0] en_q, en_d;
  logic [IRQ_W-1:0] clr_mask;

  assign clr_mask = clr_we ? clr_wdata : '0;

  always_comb begin
    stat_d = (stat_q & ~clr_mask) | set_vec;
    en_d   = en_we ? en_wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

  assign status = stat_q;
  assign en     = en_q;
  assign irq    = |(stat_q & en_q);
endmodule

// File: rtl/dring_ctrl.sv
module dring_ctrl
  import dring_pkg::*;
#(
  parameter int MAX_DESC = 16,
  localparam int IDX_W   = $clog2(MAX_DESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [1:0]       sw_addr,
  input  logic [IDX_W-1:0] sw_wdata,
  input  logic             int_en_we,
  input  logic [9:0]       int_en_wdata,
  input  logic             int_clr_we,
  input  logic [9:0]       int_clr_wdata,
  input  logic             soft_int_set,
  input  logic             wake_evt,
  input  logic             rx_adv,
  input  logic             rx_adv_irq,
  input  logic             rx_adv_err,
  input  logic             tx_adv,
  input  logic             tx_adv_irq,
  input  logic             tx_adv_err,
  output logic [IDX_W-1:0] rx_cnt,
  output logic [IDX_W-1:0] rx_prod,
  output logic [IDX_W-1:0] rx_cons,
  output logic [IDX_W-1:0] tx_cnt,
  output logic [IDX_W-1:0] tx_prod,
  output logic [IDX_W-1:0] tx_cons,
  output logic             rx_pending,
  output logic             rx_full,
  output logic             tx_pending,
  output logic             tx_full,
  output logic [9:0]       int_status,
  output logic [9:0]       int_en,
  output logic             irq
);
  sw_sel_e          sel;
  ring_ev_t         rx_ev, tx_ev;
  logic [IRQ_W-1:0] set_vec;

  assign sel = sw_sel_e'(sw_addr);

  dring_ring #(.MAX_DESC(MAX_DESC), .IDX_W(IDX_W), .HW_PRODUCES(1'b1)) rx_ring_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_we    (sw_we && (sel == SEL_RX_CNT)),
    .sw_idx_we (sw_we && (sel == SEL_RX_SW)),
    .wdata     (sw_wdata),
    .hw_adv    (rx_adv),
    .hw_irq    (rx_adv_irq),
    .hw_err    (rx_adv_err),
    .cnt       (rx_cnt),
    .prod      (rx_prod),
    .cons      (rx_cons),
    .pending   (rx_pending),
    .full      (rx_full),
    .ev        (rx_ev)
  );

  dring_ring #(.MAX_DESC(MAX_DESC), .IDX_W(IDX_W), .HW_PRODUCES(1'b0)) tx_ring_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_we    (sw_we && (sel == SEL_TX_CNT)),
    .sw_idx_we (sw_we && (sel == SEL_TX_SW)),
    .wdata     (sw_wdata),
    .hw_adv    (tx_adv),
    .hw_irq    (tx_adv_irq),
    .hw_err    (tx_adv_err),
    .cnt       (tx_cnt),
    .prod      (tx_prod),
    .cons      (tx_cons),
    .pending   (tx_pending),
    .full      (tx_full),
    .ev        (tx_ev)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[B_RX_OVR]  = rx_ev.refuse;
    set_vec[B_RX_ERR]  = rx_ev.err;
    set_vec[B_RX_FIN]  = rx_ev.fin;
    set_vec[B_RX_DONE] = rx_ev.done;
    set_vec[B_TX_UND]  = tx_ev.refuse;
    set_vec[B_TX_ERR]  = tx_ev.err;
    set_vec[B_TX_FIN]  = tx_ev.fin;
    set_vec[B_TX_DONE] = tx_ev.done;
    set_vec[B_SOFT]    = soft_int_set;
    set_vec[B_WAKE]    = wake_evt;
  end

  dring_irq #(.IRQ_W(IRQ_W)) irq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .en_we     (int_en_we),
    .en_wdata  (int_en_wdata),
    .clr_we    (int_clr_we),
    .clr_wdata (int_clr_wdata),
    .status    (int_status),
    .en        (int_en),
    .irq       (irq)
  );
endmodule

// File: rtl/dring_chk.sv
module dring_chk #(
  parameter int MAX_DESC = 16,
  localparam int IDX_W   = $clog2(MAX_DESC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_we,
  input logic [1:0]       sw_addr,
  input logic [IDX_W-1:0] sw_wdata,
  input logic             int_en_we,
  input logic [9:0]       int_en_wdata,
  input logic             int_clr_we,
  input logic [9:0]       int_clr_wdata,
  input logic             soft_int_set,
  input logic             wake_evt,
  input logic             tx_adv,
  input logic [IDX_W-1:0] rx_cnt,
  input logic [IDX_W-1:0] rx_prod,
  input logic [IDX_W-1:0] rx_cons,
  input logic [IDX_W-1:0] tx_cnt,
  input logic [IDX_W-1:0] tx_prod,
  input logic [IDX_W-1:0] tx_cons,
  input logic             tx_full,
  input logic [9:0]       int_status,
  input logic [9:0]       int_en
);
  // R4
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_prod <= rx_cnt) && (rx_cons <= rx_cnt) && (tx_prod <= tx_cnt) && (tx_cons <= tx_cnt));

  // R2
  size_write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && sw_addr == 2'd0 && int'(sw_wdata) <= MAX_DESC - 1) |=> (rx_prod == '0 && rx_cons == '0));

  // R6
  tx_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_adv && !sw_we && !int_clr_we && tx_prod == tx_cons) |=> ($stable(tx_cons) && int_status[4]));

  // R5
  empty_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt != '0 && tx_prod == tx_cons) |-> !tx_full);

  // R9
  soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_int_set |=> int_status[8]);

  // R11
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clr_we && int_clr_wdata[9] && !wake_evt) |=> !int_status[9]);

  // R10
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_en_we |=> (int_en == $past(int_en_wdata)));
endmodule

bind dring_ctrl dring_chk #(.MAX_DESC(MAX_DESC)) chk_i (.*);

// File: tb/dring_ctrl_tb_top.sv
module dring_ctrl_tb_top;
  localparam int MAX_DESC = 16;
  localparam int IDX_W    = $clog2(MAX_DESC);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             sw_we;
  logic [1:0]       sw_addr;
  logic [IDX_W-1:0] sw_wdata;
  logic             int_en_we;
  logic [9:0]       int_en_wdata;
  logic             int_clr_we;
  logic [9:0]       int_clr_wdata;
  logic             soft_int_set, wake_evt;
  logic             rx_adv, rx_adv_irq, rx_adv_err;
  logic             tx_adv, tx_adv_irq, tx_adv_err;
  logic [IDX_W-1:0] rx_cnt, rx_prod, rx_cons, tx_cnt, tx_prod, tx_cons;
  logic             rx_pending, rx_full, tx_pending, tx_full;
  logic [9:0]       int_status, int_en;
  logic             irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  dring_ctrl #(.MAX_DESC(MAX_DESC)) dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic [1:0] a, input int v);
    sw_we = 1'b1; sw_addr = a; sw_wdata = IDX_W'(v);
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic clr(input logic [9:0] m);
    int_clr_we = 1'b1; int_clr_wdata = m;
    @(negedge clk);
    int_clr_we = 1'b0;
  endtask

  task automatic tx_step(input logic rq, input logic er);
    tx_adv = 1'b1; tx_adv_irq = rq; tx_adv_err = er;
    @(negedge clk);
    tx_adv = 1'b0; tx_adv_irq = 1'b0; tx_adv_err = 1'b0;
  endtask

  task automatic rx_step(input logic rq, input logic er);
    rx_adv = 1'b1; rx_adv_irq = rq; rx_adv_err = er;
    @(negedge clk);
    rx_adv = 1'b0; rx_adv_irq = 1'b0; rx_adv_err = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rx_cnt", int'(rx_cnt), MAX_DESC - 1);
    chk("R1 tx_cnt", int'(tx_cnt), MAX_DESC - 1);
    chk("R1 indices", int'({rx_prod, rx_cons, tx_prod, tx_cons}), 0);
    chk("R1 status", int'(int_status), 0);
    chk("R1 enable", int'(int_en), 0);
    chk("R1 flags", int'({irq, rx_pending, rx_full, tx_pending, tx_full}), 0);
  endtask

  task automatic t_sizes();
    sw_write(2'd0, 3);
    chk("R2 rx size", int'(rx_cnt), 3);
    sw_write(2'd2, 3);
    chk("R2 tx size", int'(tx_cnt), 3);
    chk("R2 tx idx", int'({tx_prod, tx_cons}), 0);
  endtask

  task automatic t_tx();
    clr(10'h3FF);
    tx_step(1'b1, 1'b0);
    chk("R6 tx underrun idx", int'(tx_cons), 0);
    chk("R6 tx underrun bit", int'(int_status), 'h010);
    clr(10'h3FF);
    sw_write(2'd3, 3);
    chk("R3 tx prod load", int'(tx_prod), 3);
    chk("R5 tx full", int'({tx_full, tx_pending}), 3);
    sw_write(2'd3, 5);
    chk("R3 tx prod ignored", int'(tx_prod), 3);
    tx_step(1'b1, 1'b0);
    chk("R4 tx cons step", int'(tx_cons), 1);
    chk("R8 tx done", int'(int_status), 'h080);
    chk("R5 tx not full", int'(tx_full), 0);
    clr(10'h3FF);
    tx_step(1'b0, 1'b0);
    chk("R8 tx no done", int'(int_status), 0);
    tx_step(1'b0, 1'b0);
    chk("R7 tx finished", int'(int_status), 'h040);
    chk("R5 tx empty", int'(tx_pending), 0);
    sw_write(2'd3, 1);
    tx_step(1'b0, 1'b1);
    chk("R4 tx wrap", int'(tx_cons), 0);
    chk("R8 tx error", int'(int_status), 'h060);
    tx_step(1'b0, 1'b0);
    chk("R7 tx finished again", int'({tx_cons, tx_prod}), 'h11);
  endtask

  task automatic t_rx();
    clr(10'h3FF);
    rx_step(1'b1, 1'b0);
    chk("R4 rx prod step", int'(rx_prod), 1);
    chk("R8 rx done", int'(int_status), 'h008);
    chk("R5 rx pending", int'(rx_pending), 1);
    rx_step(1'b0, 1'b0);
    chk("R7 rx no early finish", int'(int_status), 'h008);
    rx_step(1'b0, 1'b0);
    chk("R7 rx finished", int'(int_status), 'h00C);
    chk("R5 rx full", int'(rx_full), 1);
    rx_step(1'b1, 1'b0);
    chk("R6 rx overrun idx", int'(rx_prod), 3);
    chk("R6 rx overrun bit", int'(int_status), 'h00D);
    sw_write(2'd1, 2);
    chk("R3 rx cons load", int'(rx_cons), 2);
    rx_step(1'b0, 1'b1);
    chk("R4 rx wrap", int'(rx_prod), 0);
    chk("R8 rx error", int'(int_status), 'h00F);
    sw_write(2'd1, 7);
    chk("R3 rx cons ignored", int'(rx_cons), 2);
    sw_write(2'd0, 3);
    chk("R2 rx idx zeroed", int'({rx_prod, rx_cons, rx_pending}), 0);
  endtask

  task automatic t_irq();
    clr(10'h3FF);
    int_en_we = 1'b1; int_en_wdata = 10'h100;
    @(negedge clk);
    int_en_we = 1'b0;
    chk("R10 enable load", int'(int_en), 'h100);
    chk("R10 irq idle", int'(irq), 0);
    soft_int_set = 1'b1; @(negedge clk); soft_int_set = 1'b0;
    chk("R9 soft bit", int'(int_status), 'h100);
    chk("R10 irq soft", int'(irq), 1);
    wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    chk("R9 wake bit", int'(int_status), 'h300);
    clr(10'h100);
    chk("R11 clear soft", int'(int_status), 'h200);
    chk("R10 irq masked", int'(irq), 0);
    wake_evt = 1'b1; int_clr_we = 1'b1; int_clr_wdata = 10'h200;
    @(negedge clk);
    wake_evt = 1'b0; int_clr_we = 1'b0;
    chk("R11 set wins", int'(int_status), 'h200);
    clr(10'h3FF);
    chk("R11 clear all", int'({irq, int_status}), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    sw_we = 1'b0; sw_addr = '0; sw_wdata = '0;
    int_en_we = 1'b0; int_en_wdata = '0;
    int_clr_we = 1'b0; int_clr_wdata = '0;
    soft_int_set = 1'b0; wake_evt = 1'b0;
    rx_adv = 1'b0; rx_adv_irq = 1'b0; rx_adv_err = 1'b0;
    tx_adv = 1'b0; tx_adv_irq = 1'b0; tx_adv_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_tx();
    t_rx();
    t_irq();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule